// File: doc/BRIEF.md
# Command Access Guard for an Authenticator's Non-Volatile Regions

This block sits between the command receiver of a small authentication device and its non-volatile regions. Each incoming 16-bit command code is decoded and checked against two pieces of state. The first is the seal mode: a sealed user mode, and an unsealed system mode that is entered only with the correct password. The second is a set of one-way lock flags for the root secret and for the two user pages. The block answers every command one cycle later with allow or deny. For permitted reads it also returns the data word.

The non-volatile regions are modelled as plain registers. There is one word for user page 1, one for user page 2 and one for the system page. The stored password is supplied from outside, and this block only permits or refuses its read and write commands. The block also owns the 16-bit status word. That word shows the lock flags, the seal mode and the live readiness and busy indications from neighbouring logic. It also holds three event flags that clear when the status word is read.

A hardware reset returns the register model to sealed user mode with all locks clear. After reset, only the reset event flag is set.

Top module: `nvm_access_guard`

## Requirements
- R1: After reset, `resp_valid` and `sys_mode` are 0. The first status read (code 0x0055) returns only bit 3 set, apart from the live inputs.
- R2: Code 0x8410 is allowed, and sets system mode, only when `cmd_arg` equals `sys_pwd`. With any other argument it is denied, and the mode does not change.
- R3: Code 0x8480 is always allowed, and it returns the block to user mode.
- R4: The following codes are allowed only in system mode: 0x8802 (system-page write), 0x0802 (system-page read), 0x8804 (password write) and 0x0804 (password read, which returns `sys_pwd`).
- R5: Three codes set permanent lock flags. Code 0x8235 sets the root-secret lock, 0x8245 sets the page-1 lock and 0x8255 sets the page-2 lock. These commands are always allowed. No command clears a lock, including seal and unseal.
- R6: Writes to page 1 (0x8800) and page 2 (0x8801) are denied once the matching lock is set, and the stored word stays unchanged. Reads of page 1 (0x0800) and page 2 (0x0801) are allowed in every state.
- R7: In the status word, the lock flags sit at bit 14 (page 2), bit 13 (page 1) and bit 12 (root secret). Bit 0 shows system mode. The live inputs appear at bit 10 (challenge ready), bit 9 (MAC ready), bit 8 (work secret ready) and bit 2 (busy). Bits 15, 11, 5, 4 and 1 always read 0.
- R8: Bit 7 (timeout event) and bit 6 (CRC error event) are set by their event inputs. Bit 3 is the reset flag. All three are cleared by a status read. An event that arrives in the same cycle as the read is kept for the next read.
- R9: The device-ID read (0x0805) and the ROM-ID read (0x0135) are allowed in every mode, and they return `DEV_ID_VAL` and `ROM_ID_VAL`.
- R10: Any other code is denied and changes no state.
- R11: `resp_valid` is high exactly one cycle after each `cmd_valid` cycle. `resp_rdata` is 0 for denied commands and for commands that are not reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 16 | Command code |
| cmd_arg | input | 16 | Password argument for unseal |
| cmd_wdata | input | DATA_W | Data for page writes |
| sys_pwd | input | 16 | Stored system password |
| ev_timeout | input | 1 | Timeout event pulse |
| ev_crc_err | input | 1 | CRC error event pulse |
| st_chal_rdy | input | 1 | Live challenge-ready indication |
| st_mac_rdy | input | 1 | Live MAC-ready indication |
| st_wsec_rdy | input | 1 | Live work-secret-ready indication |
| st_busy | input | 1 | Live busy indication |
| resp_valid | output | 1 | Response present |
| resp_allow | output | 1 | Command was permitted |
| resp_rdata | output | DATA_W | Read data, 0 if denied or not a read |
| sys_mode | output | 1 | System mode is active |

## Verification
Several properties are checked by assertions on every cycle:
- A lock flag never falls once set.
- Every command gets its response exactly one cycle later.
- System-only commands are refused while sealed.
- A wrong password never unseals.
- A locked page word stays stable across a write attempt.
- The event flags set and clear as specified.
- Reserved status bits stay 0 in every status response.

Only the bench scenarios can show the complete allow/deny matrix. The bench sweeps every combination of the three lock flags in both modes, and it checks the returned page, password, identifier and status values against a model that tracks earlier writes.

// File: rtl/acg_pkg.sv
package acg_pkg;

   localparam logic [15:0] C_STATUS   = 16'h0055;
   localparam logic [15:0] C_UNSEAL   = 16'h8410;
   localparam logic [15:0] C_SEAL     = 16'h8480;
   localparam logic [15:0] C_LK_ROOT  = 16'h8235;
   localparam logic [15:0] C_LK_P1    = 16'h8245;
   localparam logic [15:0] C_LK_P2    = 16'h8255;
   localparam logic [15:0] C_WR_P1    = 16'h8800;
   localparam logic [15:0] C_WR_P2    = 16'h8801;
   localparam logic [15:0] C_WR_SYS   = 16'h8802;
   localparam logic [15:0] C_WR_PWD   = 16'h8804;
   localparam logic [15:0] C_RD_P1    = 16'h0800;
   localparam logic [15:0] C_RD_P2    = 16'h0801;
   localparam logic [15:0] C_RD_SYS   = 16'h0802;
   localparam logic [15:0] C_RD_PWD   = 16'h0804;
   localparam logic [15:0] C_RD_DEVID = 16'h0805;
   localparam logic [15:0] C_RD_ROMID = 16'h0135;

   typedef enum logic [4:0] {
      CL_NONE, CL_STATUS, CL_UNSEAL, CL_SEAL,
      CL_LK_ROOT, CL_LK_P1, CL_LK_P2,
      CL_WR_P1, CL_WR_P2, CL_WR_SYS, CL_WR_PWD,
      CL_RD_P1, CL_RD_P2, CL_RD_SYS, CL_RD_PWD,
      CL_RD_DEVID, CL_RD_ROMID
   } cmd_cls_e;

   typedef struct packed {
      logic p2;
      logic p1;
      logic root;
   } lock_s;

   localparam int unsigned NUM_PAGES = 3;
   localparam int unsigned PG_P1  = 0;
   localparam int unsigned PG_P2  = 1;
   localparam int unsigned PG_SYS = 2;

   localparam int unsigned STAT_W  = 16;
   localparam int unsigned SB_LK_P2   = 14;
   localparam int unsigned SB_LK_P1   = 13;
   localparam int unsigned SB_LK_ROOT = 12;
   localparam int unsigned SB_CHAL    = 10;
   localparam int unsigned SB_MAC     = 9;
   localparam int unsigned SB_WSEC    = 8;
   localparam int unsigned SB_TMO     = 7;
   localparam int unsigned SB_CRC     = 6;
   localparam int unsigned SB_RSTF    = 3;
   localparam int unsigned SB_BUSY    = 2;
   localparam int unsigned SB_SYS     = 0;
   localparam logic [STAT_W-1:0] STAT_RSV_MASK = 16'h8832;

endpackage

// File: rtl/acg_cmd_decode.sv
module acg_cmd_decode
   import acg_pkg::*;
#(
   parameter int unsigned CODE_W = 16
)(
   input  logic [CODE_W-1:0] code,
   output cmd_cls_e          cls
);

   if (CODE_W != 16) begin : g_code_w_chk
      $error("acg_cmd_decode: CODE_W must be 16");
   end

   always_comb begin
      case (code)
         C_STATUS:   cls = CL_STATUS;
         C_UNSEAL:   cls = CL_UNSEAL;
         C_SEAL:     cls = CL_SEAL;
         C_LK_ROOT:  cls = CL_LK_ROOT;
         C_LK_P1:    cls = CL_LK_P1;
         C_LK_P2:    cls = CL_LK_P2;
         C_WR_P1:    cls = CL_WR_P1;
         C_WR_P2:    cls = CL_WR_P2;
         C_WR_SYS:   cls = CL_WR_SYS;
         C_WR_PWD:   cls = CL_WR_PWD;
         C_RD_P1:    cls = CL_RD_P1;
         C_RD_P2:    cls = CL_RD_P2;
         C_RD_SYS:   cls = CL_RD_SYS;
         C_RD_PWD:   cls = CL_RD_PWD;
         C_RD_DEVID: cls = CL_RD_DEVID;
         C_RD_ROMID: cls = CL_RD_ROMID;
         default:    cls = CL_NONE;
      endcase
   end

endmodule

// File: rtl/acg_policy.sv
module acg_policy
   import acg_pkg::*;
(
   input  cmd_cls_e cls,
   input  logic     sys_mode,
   input  lock_s    locks,
   input  logic     pwd_ok,
   output logic     allow,
   output logic     is_read
);

   always_comb begin
      allow   = 1'b0;
      is_read = 1'b0;
      case (cls)
         CL_STATUS:   begin allow = 1'b1; is_read = 1'b1; end
         CL_UNSEAL:   allow = pwd_ok;
         CL_SEAL:     allow = 1'b1;
         CL_LK_ROOT,
         CL_LK_P1,
         CL_LK_P2:    allow = 1'b1;
         CL_WR_P1:    allow = !locks.p1;
         CL_WR_P2:    allow = !locks.p2;
         CL_WR_SYS,
         CL_WR_PWD:   allow = sys_mode;
         CL_RD_SYS,
         CL_RD_PWD:   begin allow = sys_mode; is_read = 1'b1; end
         CL_RD_P1,
         CL_RD_P2,
         CL_RD_DEVID,
         CL_RD_ROMID: begin allow = 1'b1; is_read = 1'b1; end
         default:     allow = 1'b0;
      endcase
   end

endmodule

// File: rtl/acg_page_store.sv
module acg_page_store #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NPAGE  = 3
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPAGE-1:0]              wr_en,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [NPAGE-1:0][DATA_W-1:0]  pg_q
);

   if (NPAGE < 1 || NPAGE > 16) begin : g_npage_chk
      $error("acg_page_store: NPAGE out of range");
   end

   for (genvar g = 0; g < NPAGE; g++) begin : g_page
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pg_q[g] <= '0;
         end else if (wr_en[g]) begin
            pg_q[g] <= wr_data;
         end
      end

      p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_en[g] |=> $stable(pg_q[g]))
         else $error("page %0d changed without a write", g);
   end

endmodule

// File: rtl/acg_status.sv
module acg_status
   import acg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_timeout,
   input  logic              ev_crc_err,
   input  logic              rd_clr,
   input  lock_s             locks,
   input  logic              sys_mode,
   input  logic              chal_rdy,
   input  logic              mac_rdy,
   input  logic              wsec_rdy,
   input  logic              busy,
   output logic [STAT_W-1:0] word
);

   logic tmo_q, crc_q, rstf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q  <= 1'b0;
         crc_q  <= 1'b0;
         rstf_q <= 1'b1;
      end else begin
         if (ev_timeout)  tmo_q <= 1'b1;
         else if (rd_clr) tmo_q <= 1'b0;
         if (ev_crc_err)  crc_q <= 1'b1;
         else if (rd_clr) crc_q <= 1'b0;
         if (rd_clr)      rstf_q <= 1'b0;
      end
   end

   always_comb begin
      word             = '0;
      word[SB_LK_P2]   = locks.p2;
      word[SB_LK_P1]   = locks.p1;
      word[SB_LK_ROOT] = locks.root;
      word[SB_CHAL]    = chal_rdy;
      word[SB_MAC]     = mac_rdy;
      word[SB_WSEC]    = wsec_rdy;
      word[SB_TMO]     = tmo_q;
      word[SB_CRC]     = crc_q;
      word[SB_RSTF]    = rstf_q;
      word[SB_BUSY]    = busy;
      word[SB_SYS]     = sys_mode;
   end

   p_tmo_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_timeout |=> tmo_q) else $error("timeout flag not set");
   p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr && !ev_timeout |=> !tmo_q) else $error("timeout flag not cleared");
   p_crc_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr && !ev_crc_err |=> !crc_q) else $error("crc flag not cleared");
   p_rstf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> !rstf_q) else $error("reset flag not cleared");

endmodule

// File: rtl/nvm_access_guard.sv
module nvm_access_guard
   import acg_pkg::*;
#(
   parameter int unsigned       DATA_W     = 16,
   parameter logic [DATA_W-1:0] DEV_ID_VAL = 'h5A3C,
   parameter logic [DATA_W-1:0] ROM_ID_VAL = 'hC0DE
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [15:0]       cmd_code,
   input  logic [15:0]       cmd_arg,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [15:0]       sys_pwd,
   input  logic              ev_timeout,
   input  logic              ev_crc_err,
   input  logic              st_chal_rdy,
   input  logic              st_mac_rdy,
   input  logic              st_wsec_rdy,
   input  logic              st_busy,
   output logic              resp_valid,
   output logic              resp_allow,
   output logic [DATA_W-1:0] resp_rdata,
   output logic              sys_mode
);

   if (DATA_W < STAT_W || DATA_W > 64) begin : g_data_w_chk
      $error("nvm_access_guard: DATA_W must lie in 16..64");
   end

   cmd_cls_e                        cls;
   logic                            allow, is_read, pwd_ok;
   logic                            sys_q;
   lock_s                           lk_q;
   logic [NUM_PAGES-1:0]            pg_we;
   logic [NUM_PAGES-1:0][DATA_W-1:0] pg_q;
   logic [STAT_W-1:0]               stat_word;
   logic [DATA_W-1:0]               rd_val;
   logic                            take, stat_rd;
   logic                            rv_q, ra_q, rs_q;
   logic [DATA_W-1:0]               rd_q;

   assign pwd_ok  = (cmd_arg == sys_pwd);
   assign take    = cmd_valid && allow;
   assign stat_rd = cmd_valid && (cls == CL_STATUS);

   acg_cmd_decode #(.CODE_W(16)) u_dec (
      .code (cmd_code),
      .cls  (cls)
   );

   acg_policy u_pol (
      .cls      (cls),
      .sys_mode (sys_q),
      .locks    (lk_q),
      .pwd_ok   (pwd_ok),
      .allow    (allow),
      .is_read  (is_read)
   );

   always_comb begin
      pg_we         = '0;
      pg_we[PG_P1]  = take && (cls == CL_WR_P1);
      pg_we[PG_P2]  = take && (cls == CL_WR_P2);
      pg_we[PG_SYS] = take && (cls == CL_WR_SYS);
   end

   acg_page_store #(.DATA_W(DATA_W), .NPAGE(NUM_PAGES)) u_pages (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pg_we),
      .wr_data (cmd_wdata),
      .pg_q    (pg_q)
   );

   acg_status u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_timeout (ev_timeout),
      .ev_crc_err (ev_crc_err),
      .rd_clr     (stat_rd),
      .locks      (lk_q),
      .sys_mode   (sys_q),
      .chal_rdy   (st_chal_rdy),
      .mac_rdy    (st_mac_rdy),
      .wsec_rdy   (st_wsec_rdy),
      .busy       (st_busy),
      .word       (stat_word)
   );

   always_comb begin
      case (cls)
         CL_STATUS:   rd_val = DATA_W'(stat_word);
         CL_RD_P1:    rd_val = pg_q[PG_P1];
         CL_RD_P2:    rd_val = pg_q[PG_P2];
         CL_RD_SYS:   rd_val = pg_q[PG_SYS];
         CL_RD_PWD:   rd_val = DATA_W'(sys_pwd);
         CL_RD_DEVID: rd_val = DEV_ID_VAL;
         CL_RD_ROMID: rd_val = ROM_ID_VAL;
         default:     rd_val = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sys_q <= 1'b0;
         lk_q  <= '0;
      end else if (take) begin
         if (cls == CL_UNSEAL) sys_q <= 1'b1;
         if (cls == CL_SEAL)   sys_q <= 1'b0;
         if (cls == CL_LK_ROOT) lk_q.root <= 1'b1;
         if (cls == CL_LK_P1)   lk_q.p1   <= 1'b1;
         if (cls == CL_LK_P2)   lk_q.p2   <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q <= 1'b0;
         ra_q <= 1'b0;
         rs_q <= 1'b0;
         rd_q <= '0;
      end else begin
         rv_q <= cmd_valid;
         ra_q <= take;
         rs_q <= stat_rd;
         rd_q <= (take && is_read) ? rd_val : '0;
      end
   end

   assign resp_valid = rv_q;
   assign resp_allow = ra_q;
   assign resp_rdata = rd_q;
   assign sys_mode   = sys_q;

   p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> resp_valid) else $error("missing response");
   p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !resp_valid) else $error("response without command");
   p_bad_pwd_sealed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == C_UNSEAL && cmd_arg != sys_pwd && !sys_q |=> !sys_q)
      else $error("unsealed with a wrong password");
   p_sys_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !sys_q && (cmd_code == C_WR_SYS || cmd_code == C_RD_SYS ||
      cmd_code == C_WR_PWD || cmd_code == C_RD_PWD) |=> !resp_allow)
      else $error("system-only command allowed in user mode");
   p_lock_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_q.p1 |=> lk_q.p1) else $error("page-1 lock fell");
   p_lock_keep2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_q.p2 |=> lk_q.p2) else $error("page-2 lock fell");
   p_lock_keep_root_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_q.root |=> lk_q.root) else $error("root lock fell");
   p_locked_p1_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_code == C_WR_P1 && lk_q.p1 |=> $stable(pg_q[PG_P1]) && !resp_allow)
      else $error("locked page 1 written");
   p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && rs_q |-> (resp_rdata[STAT_W-1:0] & STAT_RSV_MASK) == '0)
      else $error("reserved status bit set");
   p_deny_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid && !resp_allow |-> resp_rdata == '0)
      else $error("data on denied command");

endmodule

// File: tb/test_nvm_access_guard.sv
`timescale 1ns/1ps
module test_nvm_access_guard;

   localparam logic [15:0] PWD    = 16'h1357;
   localparam logic [15:0] DEV_ID = 16'h5A3C;
   localparam logic [15:0] ROM_ID = 16'hC0DE;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] cmd_code = '0, cmd_arg = '0, cmd_wdata = '0;
   logic        ev_timeout = 1'b0, ev_crc_err = 1'b0;
   logic        st_chal_rdy = 1'b0, st_mac_rdy = 1'b0, st_wsec_rdy = 1'b0, st_busy = 1'b0;
   logic        resp_valid, resp_allow, sys_mode;
   logic [15:0] resp_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   // bench model
   bit          m_sys, m_lk1, m_lk2, m_lkr, m_tmo, m_crc, m_rstf;
   logic [15:0] m_p1, m_p2, m_ps;

   always #2.5 clk = ~clk;

   nvm_access_guard #(.DATA_W(16), .DEV_ID_VAL(DEV_ID), .ROM_ID_VAL(ROM_ID)) i_nvm_access_guard (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_arg(cmd_arg), .cmd_wdata(cmd_wdata), .sys_pwd(PWD),
      .ev_timeout(ev_timeout), .ev_crc_err(ev_crc_err),
      .st_chal_rdy(st_chal_rdy), .st_mac_rdy(st_mac_rdy),
      .st_wsec_rdy(st_wsec_rdy), .st_busy(st_busy),
      .resp_valid(resp_valid), .resp_allow(resp_allow),
      .resp_rdata(resp_rdata), .sys_mode(sys_mode)
   );

   task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [15:0] c);
      case (c)
         16'h0055: return "R7";
         16'h8410: return "R2";
         16'h8480: return "R3";
         16'h8802, 16'h0802, 16'h8804, 16'h0804: return "R4";
         16'h8235, 16'h8245, 16'h8255: return "R5";
         16'h8800, 16'h8801, 16'h0800, 16'h0801: return "R6";
         16'h0805, 16'h0135: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [15:0] stat_exp();
      logic [15:0] w = '0;
      w[14] = m_lk2; w[13] = m_lk1; w[12] = m_lkr;
      w[10] = st_chal_rdy; w[9] = st_mac_rdy; w[8] = st_wsec_rdy;
      w[7] = m_tmo; w[6] = m_crc; w[3] = m_rstf; w[2] = st_busy; w[0] = m_sys;
      return w;
   endfunction

   function automatic bit exp_allow(input logic [15:0] c, input logic [15:0] a);
      case (c)
         16'h0055, 16'h8480, 16'h8235, 16'h8245, 16'h8255,
         16'h0800, 16'h0801, 16'h0805, 16'h0135: return 1'b1;
         16'h8410: return a == PWD;
         16'h8800: return !m_lk1;
         16'h8801: return !m_lk2;
         16'h8802, 16'h0802, 16'h8804, 16'h0804: return m_sys;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] exp_data(input logic [15:0] c);
      case (c)
         16'h0055: return stat_exp();
         16'h0800: return m_p1;
         16'h0801: return m_p2;
         16'h0802: return m_ps;
         16'h0804: return PWD;
         16'h0805: return DEV_ID;
         16'h0135: return ROM_ID;
         default:  return 16'h0000;
      endcase
   endfunction

   task automatic model_update(input logic [15:0] c, input logic [15:0] wd, input bit ok, input bit eto, input bit ecrc);
      if (c == 16'h0055) begin m_tmo = 0; m_crc = 0; m_rstf = 0; end
      if (eto)  m_tmo = 1;
      if (ecrc) m_crc = 1;
      if (ok) begin
         case (c)
            16'h8410: m_sys = 1;
            16'h8480: m_sys = 0;
            16'h8235: m_lkr = 1;
            16'h8245: m_lk1 = 1;
            16'h8255: m_lk2 = 1;
            16'h8800: m_p1 = wd;
            16'h8801: m_p2 = wd;
            16'h8802: m_ps = wd;
            default: ;
         endcase
      end
   endtask

   // issue one command, compare the response, update the model
   task automatic run_cmd(input logic [15:0] c, input logic [15:0] a, input logic [15:0] wd,
                          input bit eto, input bit ecrc);
      bit          ea;
      logic [15:0] ed;
      string       rq;
      ea = exp_allow(c, a);
      ed = ea ? exp_data(c) : 16'h0000;
      rq = req_of(c);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; cmd_arg = a; cmd_wdata = wd;
      ev_timeout = eto; ev_crc_err = ecrc;
      @(negedge clk);
      cmd_valid = 1'b0; ev_timeout = 1'b0; ev_crc_err = 1'b0;
      check("R11", $sformatf("resp_valid code %h", c), {15'd0, resp_valid}, 16'd1);
      check(rq, $sformatf("allow code %h", c), {15'd0, resp_allow}, {15'd0, ea});
      check(rq, $sformatf("rdata code %h", c), resp_rdata, ed);
      model_update(c, wd, ea, eto, ecrc);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      m_sys = 0; m_lk1 = 0; m_lk2 = 0; m_lkr = 0;
      m_tmo = 0; m_crc = 0; m_rstf = 1;
      m_p1 = '0; m_p2 = '0; m_ps = '0;
      check("R1", "resp_valid after reset", {15'd0, resp_valid}, 16'd0);
      check("R1", "sys_mode after reset", {15'd0, sys_mode}, 16'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [15:0] codes [20];
      logic [15:0] args  [20];
      codes[0]  = 16'h0055; codes[1]  = 16'h8410; codes[2]  = 16'h8802; codes[3]  = 16'h0802;
      codes[4]  = 16'h8804; codes[5]  = 16'h0804; codes[6]  = 16'h8800; codes[7]  = 16'h0800;
      codes[8]  = 16'h8801; codes[9]  = 16'h0801; codes[10] = 16'h0805; codes[11] = 16'h0135;
      codes[12] = 16'h0000; codes[13] = 16'hFFFF; codes[14] = 16'h8803; codes[15] = 16'h8410;
      codes[16] = 16'h8802; codes[17] = 16'h0802; codes[18] = 16'h0804; codes[19] = 16'h0055;
      for (int i = 0; i < 20; i++) args[i] = 16'h0000;
      args[1]  = PWD ^ 16'h0001;  // wrong password
      args[15] = PWD;             // correct password

      // sweep: every lock combination x both modes x every command
      for (int lm = 0; lm < 8; lm++) begin
         do_reset();
         {st_busy, st_wsec_rdy, st_mac_rdy, st_chal_rdy} = 4'(lm * 3);
         if (lm == 0) run_cmd(16'h0055, 16'h0, 16'h0, 0, 0);   // R1: reset flag only
         if (lm[0]) run_cmd(16'h8235, 16'h0, 16'h0, 0, 0);
         if (lm[1]) run_cmd(16'h8245, 16'h0, 16'h0, 0, 0);
         if (lm[2]) run_cmd(16'h8255, 16'h0, 16'h0, 0, 0);
         for (int md = 0; md < 2; md++) begin
            if (md == 0) run_cmd(16'h8480, 16'h0, 16'h0, 0, 0);
            else         run_cmd(16'h8410, PWD, 16'h0, 0, 0);
            for (int k = 0; k < 20; k++)
               run_cmd(codes[k], args[k], {4'(lm), 4'(md), 8'(k)} ^ 16'hA500, 0, 0);
         end
         // R5: locks survive a seal / unseal round trip
         run_cmd(16'h8480, 16'h0, 16'h0, 0, 0);
         run_cmd(16'h8410, PWD, 16'h0, 0, 0);
         run_cmd(16'h0055, 16'h0, 16'h0, 0, 0);
         check("R3", "sys_mode after seal/unseal", {15'd0, sys_mode}, 16'd1);
      end

      // R8: event flags, read clears, coincident event survives
      do_reset();
      {st_busy, st_wsec_rdy, st_mac_rdy, st_chal_rdy} = 4'b0000;
      run_cmd(16'h0055, 16'h0, 16'h0, 0, 0);
      run_cmd(16'h0055, 16'h0, 16'h0, 0, 0);
      run_cmd(16'h0805, 16'h0, 16'h0, 1, 0);
      run_cmd(16'h0055, 16'h0, 16'h0, 0, 1);
      run_cmd(16'h0055, 16'h0, 16'h0, 0, 0);
      run_cmd(16'h0055, 16'h0, 16'h0, 0, 0);
      // R11: idle cycle gives no response
      @(negedge clk);
      check("R11", "resp_valid idle", {15'd0, resp_valid}, 16'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule